// File: doc/BRIEF.md
# Stride Two-Delta Load Value Predictor

This block is a direct-mapped, PC-indexed table that guesses the value a long-latency load will return. Each entry keeps an address tag, the most recent result seen for that PC, a learned stride, the most recent delta and a saturating confidence counter. When a load times out, the pipeline presents its PC on the lookup port. One cycle later the block returns the guessed value (last result plus stride), the confidence level and a forward flag. The forward flag is set only when the confidence is strictly greater than a programmable threshold. When the flag is set, the consumer forwards the guessed value to dependent instructions. When it is clear, the consumer treats the load result as invalid.

Training uses the update port, which carries each committed instruction's PC, its class and its result. The stride changes only when two consecutive deltas agree. A single irregular value therefore updates the last result and the recorded delta but leaves the learned stride unchanged. A mode input selects which commits train the table: either committed loads only, or every committed instruction except stores, branches and system calls.

Top module: `stride_vpred`

## Requirements
- R1: After reset, `rsp_valid` is 0. Every lookup misses and returns value 0, confidence 0 and forward 0.
- R2: A lookup presented in one cycle produces `rsp_valid` = 1 on the next cycle. On a hit, `rsp_value` equals last result + stride, modulo 2^VAL_W.
- R3: A lookup whose tag differs from the stored tag, or that reads an entry never written, returns value 0, confidence 0 and forward 0.
- R4: A trained update whose tag misses (re)allocates the entry. The entry then holds last result = the update value, stride 0, recorded delta 0 and confidence 0.
- R5: On a trained update that hits, delta = value − last result. The stride takes the delta only if it equals the recorded delta. The recorded delta and the last result are always refreshed.
- R6: On a trained update that hits, the confidence increments, saturating at 2^CONF_W−1, when value equals last result + stride. Otherwise the confidence resets to 0.
- R7: `rsp_use` = 1 exactly when the returned confidence is strictly greater than `cfg_thresh` sampled with the lookup.
- R8: With `cfg_train_all` = 0, only `upd_kind` = 1 (load) trains. The class encoding is 0 ALU, 1 load, 2 store, 3 branch, 4 system call, 5–7 other computing classes.
- R9: With `cfg_train_all` = 1, every class trains except 2 (store), 3 (branch) and 4 (system call).
- R10: A lookup and an update in the same cycle to the same entry make the lookup return the contents held before that update.
- R11: The entry index is `pc[IDX_W-1:0]` and the tag is the remaining upper PC bits. Two PCs sharing an index evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_train_all | input | 1 | 0: loads only train; 1: all classes except store/branch/syscall |
| cfg_thresh | input | CONF_W | Forward threshold (strictly-greater compare) |
| lk_valid | input | 1 | Lookup request for a timed-out load |
| lk_pc | input | PC_W | PC of the timed-out load |
| rsp_valid | output | 1 | Lookup response valid (one cycle after request) |
| rsp_value | output | VAL_W | Predicted load value |
| rsp_conf | output | CONF_W | Confidence of the prediction |
| rsp_use | output | 1 | 1: forward prediction; 0: invalidate the load |
| upd_valid | input | 1 | Committed-instruction update |
| upd_pc | input | PC_W | PC of the committed instruction |
| upd_kind | input | 3 | Instruction class code |
| upd_value | input | VAL_W | Committed result |

## Verification
The bench builds the block with IDX_W=2, PC_W=4, VAL_W=8 and CONF_W=3. This gives four entries and a two-bit tag, so every one of the sixteen PCs can be looked up, and index aliasing happens between PCs only four apart. The 8-bit values let strided sequences wrap around zero within a few steps. The bench sweeps every class code under both training modes and every threshold against every PC. This brings the saturation point, the strict threshold compare and the same-cycle lookup/update ordering all into reach.

// File: rtl/stride_vpred_pkg.sv
package stride_vpred_pkg;

    typedef enum logic [2:0] {
        KIND_ALU     = 3'd0,
        KIND_LOAD    = 3'd1,
        KIND_STORE   = 3'd2,
        KIND_BRANCH  = 3'd3,
        KIND_SYSCALL = 3'd4,
        KIND_MUL     = 3'd5,
        KIND_FPU     = 3'd6,
        KIND_MISC    = 3'd7
    } op_kind_e;

    typedef enum logic {
        TRAIN_LOADS = 1'b0,
        TRAIN_ALL   = 1'b1
    } train_mode_e;

endpackage

// File: rtl/stride_vpred_filter.sv
module stride_vpred_filter
    import stride_vpred_pkg::*;
(
    input  logic       upd_valid,
    input  logic [2:0] upd_kind,
    input  logic       train_all,
    output logic       train_en
);

    op_kind_e    kind;
    train_mode_e mode;

    assign kind = op_kind_e'(upd_kind);
    assign mode = train_mode_e'(train_all);

    always_comb begin
        train_en = 1'b0;
        if (upd_valid) begin
            unique case (mode)
                TRAIN_LOADS: train_en = (kind == KIND_LOAD);
                TRAIN_ALL: begin
                    unique case (kind)
                        KIND_STORE, KIND_BRANCH, KIND_SYSCALL: train_en = 1'b0;
                        default:                               train_en = 1'b1;
                    endcase
                end
                default: train_en = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/stride_vpred_train.sv
module stride_vpred_train #(
    parameter int VAL_W  = 32,
    parameter int CONF_W = 3
) (
    input  logic              hit,
    input  logic [VAL_W-1:0]  last_q,
    input  logic [VAL_W-1:0]  stride_q,
    input  logic [VAL_W-1:0]  ldelta_q,
    input  logic [CONF_W-1:0] conf_q,
    input  logic [VAL_W-1:0]  value,
    output logic [VAL_W-1:0]  last_d,
    output logic [VAL_W-1:0]  stride_d,
    output logic [VAL_W-1:0]  ldelta_d,
    output logic [CONF_W-1:0] conf_d
);

    localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

    logic [VAL_W-1:0] delta;
    logic [VAL_W-1:0] guess;
    logic             guess_ok;

    assign delta    = value - last_q;
    assign guess    = last_q + stride_q;
    assign guess_ok = (guess == value);

    always_comb begin
        last_d = value;
        if (!hit) begin
            stride_d = '0;
            ldelta_d = '0;
            conf_d   = '0;
        end else begin
            ldelta_d = delta;
            stride_d = (delta == ldelta_q) ? delta : stride_q;
            if (!guess_ok)
                conf_d = '0;
            else if (conf_q == CONF_MAX)
                conf_d = conf_q;
            else
                conf_d = conf_q + 1'b1;
        end
    end

    always_comb begin
        AST_CONF_STEP: assert (!hit || conf_d == '0 || conf_d == conf_q || conf_d == conf_q + 1'b1); // R6
        AST_STRIDE_TWO_DELTA: assert (!hit || stride_d == stride_q || delta == ldelta_q); // R5
    end

endmodule

// File: rtl/stride_vpred.sv
module stride_vpred
    import stride_vpred_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int PC_W   = 32,
    parameter int VAL_W  = 32,
    parameter int CONF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_train_all,
    input  logic [CONF_W-1:0] cfg_thresh,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              rsp_valid,
    output logic [VAL_W-1:0]  rsp_value,
    output logic [CONF_W-1:0] rsp_conf,
    output logic              rsp_use,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [2:0]        upd_kind,
    input  logic [VAL_W-1:0]  upd_value
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = PC_W - IDX_W;

    logic [ENTRIES-1:0] tbl_vld;
    logic [TAG_W-1:0]   tbl_tag    [ENTRIES];
    logic [VAL_W-1:0]   tbl_last   [ENTRIES];
    logic [VAL_W-1:0]   tbl_stride [ENTRIES];
    logic [VAL_W-1:0]   tbl_ldelta [ENTRIES];
    logic [CONF_W-1:0]  tbl_conf   [ENTRIES];

    // lookup side
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic             lk_hit;
    logic             rsp_hit_q;

    assign lk_idx = lk_pc[IDX_W-1:0];
    assign lk_tag = lk_pc[PC_W-1:IDX_W];
    assign lk_hit = tbl_vld[lk_idx] && (tbl_tag[lk_idx] == lk_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit_q <= 1'b0;
            rsp_value <= '0;
            rsp_conf  <= '0;
            rsp_use   <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit_q <= lk_valid && lk_hit;
            if (lk_valid && lk_hit) begin
                rsp_value <= tbl_last[lk_idx] + tbl_stride[lk_idx];
                rsp_conf  <= tbl_conf[lk_idx];
                rsp_use   <= (tbl_conf[lk_idx] > cfg_thresh);
            end else begin
                rsp_value <= '0;
                rsp_conf  <= '0;
                rsp_use   <= 1'b0;
            end
        end
    end

    // update side
    logic [IDX_W-1:0]  upd_idx;
    logic [TAG_W-1:0]  upd_tag;
    logic              upd_hit;
    logic              train_en;
    logic [VAL_W-1:0]  nxt_last;
    logic [VAL_W-1:0]  nxt_stride;
    logic [VAL_W-1:0]  nxt_ldelta;
    logic [CONF_W-1:0] nxt_conf;

    assign upd_idx = upd_pc[IDX_W-1:0];
    assign upd_tag = upd_pc[PC_W-1:IDX_W];
    assign upd_hit = tbl_vld[upd_idx] && (tbl_tag[upd_idx] == upd_tag);

    stride_vpred_filter filter_i (
        .upd_valid (upd_valid),
        .upd_kind  (upd_kind),
        .train_all (cfg_train_all),
        .train_en  (train_en)
    );

    stride_vpred_train #(
        .VAL_W  (VAL_W),
        .CONF_W (CONF_W)
    ) train_i (
        .hit      (upd_hit),
        .last_q   (tbl_last[upd_idx]),
        .stride_q (tbl_stride[upd_idx]),
        .ldelta_q (tbl_ldelta[upd_idx]),
        .conf_q   (tbl_conf[upd_idx]),
        .value    (upd_value),
        .last_d   (nxt_last),
        .stride_d (nxt_stride),
        .ldelta_d (nxt_ldelta),
        .conf_d   (nxt_conf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_vld <= '0;
        end else if (train_en) begin
            tbl_vld[upd_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (train_en) begin
            tbl_tag[upd_idx]    <= upd_tag;
            tbl_last[upd_idx]   <= nxt_last;
            tbl_stride[upd_idx] <= nxt_stride;
            tbl_ldelta[upd_idx] <= nxt_ldelta;
            tbl_conf[upd_idx]   <= nxt_conf;
        end
    end

    AST_RSP_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid)); // R2

    AST_USE_NEEDS_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_use) |-> (rsp_conf > $past(cfg_thresh))); // R7

    AST_MISS_NO_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit_q) |-> (rsp_conf == '0 && !rsp_use && rsp_value == '0)); // R3

    AST_FILTER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_kind == KIND_STORE || upd_kind == KIND_BRANCH || upd_kind == KIND_SYSCALL) |-> !train_en); // R9

    AST_LOADS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_train_all && upd_kind != KIND_LOAD) |-> !train_en); // R8

endmodule

// File: tb/stride_vpred_tb_top.sv
`timescale 1ns/1ps
module stride_vpred_tb_top;

    localparam int IDX_W = 2;
    localparam int PC_W  = 4;
    localparam int VAL_W = 8;
    localparam int CONF_W = 3;
    localparam int NENT  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_train_all = 1'b0;
    logic [CONF_W-1:0] cfg_thresh = '0;
    logic lk_valid = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic rsp_valid;
    logic [VAL_W-1:0] rsp_value;
    logic [CONF_W-1:0] rsp_conf;
    logic rsp_use;
    logic upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic [2:0] upd_kind = '0;
    logic [VAL_W-1:0] upd_value = '0;

    int n_vec = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stride_vpred #(.IDX_W(IDX_W), .PC_W(PC_W), .VAL_W(VAL_W), .CONF_W(CONF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_train_all(cfg_train_all), .cfg_thresh(cfg_thresh),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .rsp_valid(rsp_valid), .rsp_value(rsp_value),
        .rsp_conf(rsp_conf), .rsp_use(rsp_use), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_kind(upd_kind), .upd_value(upd_value)
    );

    // reference model state
    bit              m_vld    [NENT];
    logic [1:0]      m_tag    [NENT];
    logic [VAL_W-1:0] m_last  [NENT];
    logic [VAL_W-1:0] m_stride[NENT];
    logic [VAL_W-1:0] m_ldelta[NENT];
    int              m_conf   [NENT];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit m_trains(input int kind, input bit all);
        if (!all) return kind == 1;
        return !(kind == 2 || kind == 3 || kind == 4);
    endfunction

    task automatic m_update(input logic [3:0] pc, input int kind, input logic [7:0] val);
        int idx = int'(pc[1:0]);
        logic [7:0] d;
        if (!m_trains(kind, cfg_train_all)) return;
        if (!(m_vld[idx] && m_tag[idx] == pc[3:2])) begin
            m_vld[idx] = 1'b1; m_tag[idx] = pc[3:2];
            m_last[idx] = val; m_stride[idx] = 0; m_ldelta[idx] = 0; m_conf[idx] = 0;
        end else begin
            d = val - m_last[idx];
            if (8'(m_last[idx] + m_stride[idx]) == val) m_conf[idx] = (m_conf[idx] == 7) ? 7 : m_conf[idx] + 1;
            else m_conf[idx] = 0;
            if (d == m_ldelta[idx]) m_stride[idx] = d;
            m_ldelta[idx] = d;
            m_last[idx] = val;
        end
    endtask

    task automatic step(input bit uv, input logic [3:0] upc, input int uk, input logic [7:0] uval,
                        input bit lv, input logic [3:0] lpc, input string tag);
        int li = int'(lpc[1:0]);
        int ev = 0, ec = 0, eu = 0;
        if (m_vld[li] && m_tag[li] == lpc[3:2]) begin
            ev = int'(8'(m_last[li] + m_stride[li]));
            ec = m_conf[li];
            eu = (ec > int'(cfg_thresh)) ? 1 : 0;
        end
        upd_valid = uv; upd_pc = upc; upd_kind = 3'(uk); upd_value = uval;
        lk_valid = lv; lk_pc = lpc;
        if (uv) m_update(upc, uk, uval);
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0; lk_valid = 1'b0;
        chk(tag, "rsp_valid", int'(rsp_valid), int'(lv));
        if (lv) begin
            chk(tag, "rsp_value", int'(rsp_value), ev);
            chk(tag, "rsp_conf", int'(rsp_conf), ec);
            chk(tag, "rsp_use", int'(rsp_use), eu);
        end
    endtask

    task automatic look(input logic [3:0] pc, input string tag);
        step(1'b0, 4'd0, 0, 8'd0, 1'b1, pc, tag);
    endtask

    task automatic train(input logic [3:0] pc, input logic [7:0] v, input string tag);
        step(1'b1, pc, 1, v, 1'b1, pc, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NENT; i++) begin
            m_vld[i] = 0; m_tag[i] = 0; m_last[i] = 0; m_stride[i] = 0; m_ldelta[i] = 0; m_conf[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        chk("R1", "rsp_conf after reset", int'(rsp_conf), 0);
        for (int p = 0; p < 16; p++) look(4'(p), "R1");

        // allocation
        step(1'b1, 4'd5, 1, 8'd100, 1'b0, 4'd0, "R4");
        look(4'd5, "R4");
        look(4'd1, "R3");
        look(4'd13, "R3");

        // two-delta stride with same-cycle lookup, threshold varied
        for (int i = 0; i < 14; i++) begin
            cfg_thresh = 3'(i % 8);
            train(4'd6, 8'(10 + 3 * i), "R10");
            look(4'd6, "R5");
        end
        train(4'd6, 8'd200, "R6");
        look(4'd6, "R6");
        train(4'd6, 8'd203, "R5");
        look(4'd6, "R5");
        train(4'd6, 8'd206, "R5");
        look(4'd6, "R2");

        // alternating values never settle a stride
        for (int i = 0; i < 8; i++) begin
            train(4'd7, (i % 2 == 0) ? 8'd1 : 8'd5, "R5");
            look(4'd7, "R5");
        end

        // wraparound and saturation
        for (int i = 0; i < 20; i++) train(4'd9, 8'(240 + 7 * i), "R6");
        look(4'd9, "R2");

        // class filter sweep
        for (int m = 0; m < 2; m++) begin
            cfg_train_all = 1'(m);
            for (int k = 0; k < 8; k++) begin
                step(1'b1, 4'd3, k, 8'(7 * k + 60 * m + 1), 1'b0, 4'd0, (m == 0) ? "R8" : "R9");
                look(4'd3, (m == 0) ? "R8" : "R9");
            end
        end
        cfg_train_all = 1'b0;

        // aliasing
        step(1'b1, 4'd1, 1, 8'd40, 1'b0, 4'd0, "R11");
        look(4'd1, "R11");
        look(4'd5, "R11");
        step(1'b1, 4'd5, 1, 8'd80, 1'b0, 4'd0, "R11");
        look(4'd1, "R11");
        look(4'd5, "R11");

        // threshold sweep over all pcs
        for (int t = 0; t < 8; t++) begin
            cfg_thresh = 3'(t);
            for (int p = 0; p < 16; p++) look(4'(p), "R7");
        end

        finish_run();
    end

endmodule